// File: doc/BRIEF.md
# Stack Pop Sequencer

This block carries out the 16-bit stack pop instructions inside a small microcoded processor core. When `start` is pulsed with an opcode, the block decodes that opcode into one of four destination kinds: a general register, a segment register, the flags register, or a memory operand. It then reads one word from the stack at the stack-segment address given by the current stack pointer. After the read completes, it writes the stack pointer back advanced by one word. Last, it hands the popped word to its destination and raises `done` for one cycle.

Instruction fetch, effective-address computation and the arithmetic unit belong to the surrounding core. The effective address of a memory operand arrives already computed on `ea`. For the register or memory form of the pop (opcode 0x8F), the core also supplies the ModR/M operand kind and rm field. The block has four external connections:

- a read port on the register file, used to fetch SP;
- a write port on the register file;
- separate write ports for the segment registers and the flags;
- a request/ready memory port.

Top module: `stack_pop_seq`

## Requirements
- R1: Opcodes 0x58..0x5F write the popped word to register index 0..7 respectively (index order AX=0, CX=1, DX=2, BX=3, SP=4, BP=5, SI=6, DI=7), and SP ends at its starting value plus 2.
- R2: Opcode 0x07 writes the popped word to segment index 0 (ES), 0x17 to index 2 (SS) and 0x1F to index 3 (DS). The segment codes are ES=0, CS=1, SS=2, DS=3.
- R3: Every pop reads at `mem_addr` equal to the SP value at start, with `mem_seg`=2 (SS). SP is rewritten with SP+2 only after that read has completed and before the destination is written.
- R4: For opcode 0x5C the destination write follows the increment, so SP ends equal to the popped word.
- R5: A segment pop raises `int_inhibit` for exactly one cycle, in the same cycle as `done` and `seg_wr_en`. No other pop raises `int_inhibit`.
- R6: Opcode 0x9D writes flags equal to (popped & 0x0FD5) | (current & 0xF02A). The updated bits are 0, 2, 4, 6, 7, 8, 9, 10 and 11. `flags_wr_en` is never raised by any other opcode.
- R7: Opcode 0x8F with a memory operand (`rm_is_reg`=0) writes the popped word once to `ea` with `mem_seg`=3 (DS), after SP has been rewritten. `done` follows the accepted write.
- R8: Opcode 0x8F with a register operand (`rm_is_reg`=1) writes the popped word to the register named by `rm`.
- R9: A memory request keeps its address, segment and direction until `mem_ready` is seen. Each wait cycle delays `done` by one cycle. A `start` while the block is busy has no effect.
- R10: Any other opcode raises `illegal` with `done` in the cycle after start, and causes no register, segment, flags or memory activity.
- R11: After reset `done`, `mem_req` and all write enables are low. `done` lasts one cycle per instruction. With zero-wait memory it appears 4 cycles after the start cycle for register, segment and flag pops, and 5 cycles after for memory pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (accepted only while idle) |
| opcode | input | 8 | Primary opcode byte |
| rm_is_reg | input | 1 | ModR/M operand of 0x8F is a register |
| rm | input | 3 | ModR/M rm field for 0x8F |
| ea | input | 16 | Effective address for a memory operand |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_seg | output | 2 | Segment used by the request |
| mem_addr | output | 16 | Offset of the request |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Request accepted/completed |
| rf_rd_idx | output | 3 | Register-file read index (SP) |
| rf_rd_data | input | 16 | Register-file read data |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_idx | output | 3 | Register-file write index |
| rf_wr_data | output | 16 | Register-file write data |
| seg_wr_en | output | 1 | Segment-register write enable |
| seg_wr_idx | output | 2 | Segment-register index |
| seg_wr_data | output | 16 | Segment-register data |
| flags_cur | input | 16 | Current flags value |
| flags_wr_en | output | 1 | Flags write enable |
| flags_wr_data | output | 16 | New flags value |
| int_inhibit | output | 1 | Hold off external interrupts for the next instruction |
| done | output | 1 | Instruction finished |
| illegal | output | 1 | Opcode not handled (with `done`) |

## Verification
The bench builds the block with its defaults: 16-bit words, 16-bit offsets so that the direct address path is taken, a flag mask of 0x0FD5 and SP at index 4. At these settings the SP override by 0x5C and the merge of kept and replaced flag bits can both be reached. So can every segment index that the opcode bits select. The bench's memory model inserts a chosen number of wait cycles on each request. This brings the held request and the stretched `done` latency within reach, and so does a second `start` that lands while a read is outstanding.

// File: rtl/pop_pkg.sv
package pop_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_READ,
      ST_BUMP,
      ST_WRITE,
      ST_DELIVER,
      ST_FIN
   } pop_state_t;

   typedef enum logic [2:0] {
      DST_GPR,
      DST_SEG,
      DST_FLAGS,
      DST_MEM,
      DST_BAD
   } pop_dest_t;

   localparam logic [1:0] SEG_ES = 2'd0;
   localparam logic [1:0] SEG_CS = 2'd1;
   localparam logic [1:0] SEG_SS = 2'd2;
   localparam logic [1:0] SEG_DS = 2'd3;

   localparam logic [7:0] OPC_GPR_BASE = 8'h58;
   localparam logic [7:0] OPC_POP_ES   = 8'h07;
   localparam logic [7:0] OPC_POP_SS   = 8'h17;
   localparam logic [7:0] OPC_POP_DS   = 8'h1F;
   localparam logic [7:0] OPC_POPF     = 8'h9D;
   localparam logic [7:0] OPC_POP_RM   = 8'h8F;

endpackage

// File: rtl/pop_decode.sv
module pop_decode
   import pop_pkg::*;
#(
   parameter int OPC_W     = 8,
   parameter int REG_IDX_W = 3
) (
   input  logic [OPC_W-1:0]     opcode,
   input  logic                 rm_is_reg,
   input  logic [REG_IDX_W-1:0] rm,
   output pop_dest_t            dest,
   output logic [REG_IDX_W-1:0] dst_idx
);
   localparam int N_GPR = 1 << REG_IDX_W;

   initial begin
      assert (OPC_W == 8) else $error("pop_decode: opcode width must be 8");
      assert (REG_IDX_W == 3) else $error("pop_decode: eight general registers expected");
   end

   logic [N_GPR-1:0]     gpr_hit;
   logic [REG_IDX_W-1:0] gpr_idx;

   // one comparator per short-form register opcode
   for (genvar g = 0; g < N_GPR; g++) begin : g_gpr_cmp
      assign gpr_hit[g] = (opcode == (OPC_GPR_BASE + OPC_W'(g)));
   end

   always_comb begin
      gpr_idx = '0;
      for (int k = 0; k < N_GPR; k++) begin
         if (gpr_hit[k]) gpr_idx = REG_IDX_W'(k);
      end
   end

   always_comb begin
      dest    = DST_BAD;
      dst_idx = '0;
      if (|gpr_hit) begin
         dest    = DST_GPR;
         dst_idx = gpr_idx;
      end else if (opcode == OPC_POP_ES || opcode == OPC_POP_SS || opcode == OPC_POP_DS) begin
         dest    = DST_SEG;
         // opcode bits 4:3 carry the segment code
         dst_idx = REG_IDX_W'(opcode[4:3]);
      end else if (opcode == OPC_POPF) begin
         dest = DST_FLAGS;
      end else if (opcode == OPC_POP_RM) begin
         if (rm_is_reg) begin
            dest    = DST_GPR;
            dst_idx = rm;
         end else begin
            dest = DST_MEM;
         end
      end
   end
endmodule

// File: rtl/pop_fsm.sv
module pop_fsm
   import pop_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       legal,
   input  logic       to_mem,
   input  logic       mem_ready,
   output pop_state_t state
);
   pop_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:    if (start) nxt = legal ? ST_LOAD : ST_FIN;
         ST_LOAD:    nxt = ST_READ;
         ST_READ:    if (mem_ready) nxt = ST_BUMP;
         ST_BUMP:    nxt = to_mem ? ST_WRITE : ST_DELIVER;
         ST_WRITE:   if (mem_ready) nxt = ST_FIN;
         ST_DELIVER: nxt = ST_IDLE;
         ST_FIN:     nxt = ST_IDLE;
         default:    nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && state != ST_FIN && state != ST_DELIVER && !(state == ST_READ && mem_ready)
       && !(state == ST_WRITE && mem_ready) && state != ST_LOAD && state != ST_BUMP)
      |=> state == $past(state)); // R9
endmodule

// File: rtl/pop_flag_merge.sv
module pop_flag_merge #(
   parameter int             DATA_W    = 16,
   parameter logic [DATA_W-1:0] FLAG_MASK = 16'h0FD5
) (
   input  logic [DATA_W-1:0] popped,
   input  logic [DATA_W-1:0] current,
   output logic [DATA_W-1:0] merged
);
   initial begin
      assert (FLAG_MASK != '0) else $error("pop_flag_merge: empty flag mask");
   end

   // each bit is either taken from the stack word or kept
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (FLAG_MASK[b]) begin : g_take
         assign merged[b] = popped[b];
      end else begin : g_keep
         assign merged[b] = current[b];
      end
   end
endmodule

// File: rtl/stack_pop_seq.sv
module stack_pop_seq
   import pop_pkg::*;
#(
   parameter int             DATA_W    = 16,
   parameter int             ADDR_W    = 16,
   parameter int             REG_IDX_W = 3,
   parameter int             SEG_IDX_W = 2,
   parameter int             SP_IDX    = 4,
   parameter logic [15:0]    FLAG_MASK = 16'h0FD5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [7:0]           opcode,
   input  logic                 rm_is_reg,
   input  logic [REG_IDX_W-1:0] rm,
   input  logic [ADDR_W-1:0]    ea,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [SEG_IDX_W-1:0] mem_seg,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [DATA_W-1:0]    mem_wdata,
   input  logic [DATA_W-1:0]    mem_rdata,
   input  logic                 mem_ready,
   output logic [REG_IDX_W-1:0] rf_rd_idx,
   input  logic [DATA_W-1:0]    rf_rd_data,
   output logic                 rf_wr_en,
   output logic [REG_IDX_W-1:0] rf_wr_idx,
   output logic [DATA_W-1:0]    rf_wr_data,
   output logic                 seg_wr_en,
   output logic [SEG_IDX_W-1:0] seg_wr_idx,
   output logic [DATA_W-1:0]    seg_wr_data,
   input  logic [DATA_W-1:0]    flags_cur,
   output logic                 flags_wr_en,
   output logic [DATA_W-1:0]    flags_wr_data,
   output logic                 int_inhibit,
   output logic                 done,
   output logic                 illegal
);
   localparam int SP_STEP = DATA_W / 8;
   localparam logic [REG_IDX_W-1:0] SP_SEL = REG_IDX_W'(SP_IDX);

   initial begin
      assert (DATA_W % 8 == 0 && DATA_W >= 16) else $error("stack_pop_seq: bad DATA_W");
      assert (ADDR_W >= 8 && ADDR_W <= 32) else $error("stack_pop_seq: bad ADDR_W");
      assert (SEG_IDX_W == 2) else $error("stack_pop_seq: four segments expected");
      assert (SP_IDX < (1 << REG_IDX_W)) else $error("stack_pop_seq: SP index out of range");
   end

   // decode of the incoming opcode
   pop_dest_t            dec_dest;
   logic [REG_IDX_W-1:0] dec_idx;

   pop_decode #(.OPC_W(8), .REG_IDX_W(REG_IDX_W)) u_dec (
      .opcode    (opcode),
      .rm_is_reg (rm_is_reg),
      .rm        (rm),
      .dest      (dec_dest),
      .dst_idx   (dec_idx)
   );

   // instruction state captured at start
   pop_dest_t            dest_q;
   logic [REG_IDX_W-1:0] idx_q;
   logic [ADDR_W-1:0]    ea_q;
   logic [DATA_W-1:0]    sp_q;
   logic [DATA_W-1:0]    mdr_q;
   logic                 ill_q;
   pop_state_t           state;

   pop_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .legal     (dec_dest != DST_BAD),
      .to_mem    (dest_q == DST_MEM),
      .mem_ready (mem_ready),
      .state     (state)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dest_q <= DST_BAD;
         idx_q  <= '0;
         ea_q   <= '0;
         sp_q   <= '0;
         mdr_q  <= '0;
         ill_q  <= 1'b0;
      end else begin
         if (state == ST_IDLE && start) begin
            dest_q <= dec_dest;
            idx_q  <= dec_idx;
            ea_q   <= ea;
            ill_q  <= (dec_dest == DST_BAD);
         end
         if (state == ST_LOAD) sp_q <= rf_rd_data;
         if (state == ST_READ && mem_ready) mdr_q <= mem_rdata;
      end
   end

   // stack offset taken from SP, sized to the address port
   logic [ADDR_W-1:0] stack_addr;
   if (ADDR_W == DATA_W) begin : g_addr_direct
      assign stack_addr = sp_q;
   end else if (ADDR_W < DATA_W) begin : g_addr_trunc
      assign stack_addr = sp_q[ADDR_W-1:0];
   end else begin : g_addr_zext
      assign stack_addr = {{(ADDR_W-DATA_W){1'b0}}, sp_q};
   end

   logic [DATA_W-1:0] merged_flags;
   pop_flag_merge #(.DATA_W(DATA_W), .FLAG_MASK(DATA_W'(FLAG_MASK))) u_flags (
      .popped  (mdr_q),
      .current (flags_cur),
      .merged  (merged_flags)
   );

   logic in_deliver;
   assign in_deliver = (state == ST_DELIVER);

   always_comb begin
      mem_req   = (state == ST_READ) || (state == ST_WRITE);
      mem_we    = (state == ST_WRITE);
      mem_seg   = (state == ST_WRITE) ? SEG_DS : SEG_SS;
      mem_addr  = (state == ST_WRITE) ? ea_q : stack_addr;
      mem_wdata = mdr_q;

      rf_rd_idx  = SP_SEL;
      rf_wr_en   = (state == ST_BUMP) || (in_deliver && dest_q == DST_GPR);
      rf_wr_idx  = (state == ST_BUMP) ? SP_SEL : idx_q;
      rf_wr_data = (state == ST_BUMP) ? (sp_q + DATA_W'(SP_STEP)) : mdr_q;

      seg_wr_en   = in_deliver && dest_q == DST_SEG;
      seg_wr_idx  = idx_q[SEG_IDX_W-1:0];
      seg_wr_data = mdr_q;

      flags_wr_en   = in_deliver && dest_q == DST_FLAGS;
      flags_wr_data = merged_flags;

      int_inhibit = in_deliver && dest_q == DST_SEG;
      done        = in_deliver || (state == ST_FIN);
      illegal     = (state == ST_FIN) && ill_q;
   end

   AST_READ_IN_STACK_SEG: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> mem_seg == SEG_SS); // R3
   AST_SP_BUMP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ready) |=> (rf_wr_en && rf_wr_idx == SP_SEL && !done)); // R3
   AST_WRITE_IN_DATA_SEG: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_seg == SEG_DS); // R7
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_seg))); // R9
   AST_INHIBIT_WITH_SEG: assert property (@(posedge clk) disable iff (!rst_n)
      int_inhibit |-> (seg_wr_en && done)); // R5
   AST_INHIBIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      int_inhibit |=> !int_inhibit); // R5
   AST_FLAGS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      flags_wr_en |-> (done && !rf_wr_en && !seg_wr_en)); // R6
   AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (done && !rf_wr_en && !seg_wr_en && !flags_wr_en && !mem_req)); // R10
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11
   AST_ONE_SINK: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({rf_wr_en, seg_wr_en, flags_wr_en, mem_req && mem_we}) <= 1); // R1
endmodule

// File: tb/stack_pop_seq_test.sv
module stack_pop_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic        rm_is_reg = 1'b0;
   logic [2:0]  rm = 3'd0;
   logic [15:0] ea = 16'h0;
   logic        mem_req, mem_we;
   logic [1:0]  mem_seg;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_ready = 1'b0;
   logic [2:0]  rf_rd_idx, rf_wr_idx;
   logic [15:0] rf_rd_data, rf_wr_data;
   logic        rf_wr_en, seg_wr_en, flags_wr_en;
   logic [1:0]  seg_wr_idx;
   logic [15:0] seg_wr_data, flags_wr_data;
   logic [15:0] flags_cur = 16'h0;
   logic        int_inhibit, done, illegal;

   always #10 clk = ~clk;

   stack_pop_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .rm_is_reg(rm_is_reg), .rm(rm), .ea(ea),
      .mem_req(mem_req), .mem_we(mem_we), .mem_seg(mem_seg), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
      .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
      .seg_wr_en(seg_wr_en), .seg_wr_idx(seg_wr_idx), .seg_wr_data(seg_wr_data),
      .flags_cur(flags_cur), .flags_wr_en(flags_wr_en), .flags_wr_data(flags_wr_data),
      .int_inhibit(int_inhibit), .done(done), .illegal(illegal)
   );

   // environment models
   logic [15:0] regs [0:7];
   logic [15:0] segs [0:3];
   logic [15:0] smem [0:255];
   int          wait_n = 0;
   int          wcnt = 0;
   int          rd_cnt = 0, wr_cnt = 0, done_cnt = 0, inh_cnt = 0, flw_cnt = 0, sgw_cnt = 0;
   logic [15:0] rd_addr, wr_addr, wr_data, sp_at_wr;
   logic [1:0]  rd_seg, wr_seg;

   assign rf_rd_data = regs[rf_rd_idx];
   assign mem_rdata  = smem[mem_addr[8:1]];

   always @(posedge clk) begin
      if (rf_wr_en) regs[rf_wr_idx] <= rf_wr_data;
      if (seg_wr_en) begin segs[seg_wr_idx] <= seg_wr_data; sgw_cnt <= sgw_cnt + 1; end
      if (flags_wr_en) begin flags_cur <= flags_wr_data; flw_cnt <= flw_cnt + 1; end
      if (mem_req && mem_ready && !mem_we) begin
         rd_cnt <= rd_cnt + 1; rd_addr <= mem_addr; rd_seg <= mem_seg;
      end
      if (mem_req && mem_ready && mem_we) begin
         wr_cnt <= wr_cnt + 1; wr_addr <= mem_addr; wr_seg <= mem_seg;
         wr_data <= mem_wdata; sp_at_wr <= regs[4];
      end
   end

   always @(negedge clk) begin
      if (!mem_req) begin wcnt = 0; mem_ready = 1'b0; end
      else begin mem_ready = (wcnt >= wait_n); wcnt = wcnt + 1; end
      if (rst_n && done) done_cnt = done_cnt + 1;
      if (rst_n && int_inhibit) inh_cnt = inh_cnt + 1;
   end

   int n_chk = 0, n_fail = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // run one instruction; latency counted in cycles after the start cycle
   task automatic run_pop(input logic [7:0] op, input bit isreg, input logic [2:0] rmv,
                          input logic [15:0] eav, input int wt, input bit inject,
                          output int lat, output bit ill);
      wait_n = wt;
      @(negedge clk);
      start = 1'b1; opcode = op; rm_is_reg = isreg; rm = rmv; ea = eav;
      lat = 0; ill = 1'b0;
      for (int c = 0; c < 60; c++) begin
         @(negedge clk);
         lat++;
         start = 1'b0;
         if (inject && lat == 2) begin start = 1'b1; opcode = 8'h5B; end
         if (done) begin ill = illegal; break; end
      end
      start = 1'b0;
      if (!done) check(1'b0, "R11 watchdog on done", 32'(lat), 32'd0);
      @(negedge clk);
   endtask

   task automatic clear_regs();
      for (int i = 0; i < 8; i++) regs[i] = 16'h1000 + 16'(i);
      for (int i = 0; i < 4; i++) segs[i] = 16'h2000 + 16'(i);
   endtask

   task automatic t_reset();
      check(done == 1'b0 && illegal == 1'b0, "R11 reset done/illegal", {30'd0, done, illegal}, 0);
      check(mem_req == 1'b0, "R11 reset mem_req", 32'(mem_req), 0);
      check({rf_wr_en, seg_wr_en, flags_wr_en, int_inhibit} == 4'd0, "R11 reset enables",
            {28'd0, rf_wr_en, seg_wr_en, flags_wr_en, int_inhibit}, 0);
   endtask

   task automatic t_gpr();
      int lat; bit ill; int d0;
      for (int i = 0; i < 8; i++) begin
         logic [15:0] sp0;
         clear_regs();
         sp0 = 16'h0040 + 16'(i * 8);
         regs[4] = sp0;
         smem[sp0[8:1]] = 16'hA000 + 16'(i);
         d0 = done_cnt;
         run_pop(8'h58 + 8'(i), 1'b0, 3'd0, 16'h0, 0, 1'b0, lat, ill);
         if (i != 4) begin
            check(regs[i] == 16'hA000 + 16'(i), "R1 gpr destination", regs[i], 16'hA000 + 16'(i));
            check(regs[4] == sp0 + 16'd2, "R1 SP advanced by 2", regs[4], sp0 + 16'd2);
         end else begin
            check(regs[4] == 16'hA004, "R4 SP overridden by popped word", regs[4], 16'hA004);
         end
         check(rd_addr == sp0 && rd_seg == 2'd2, "R3 read at SS:SP", {rd_seg, 14'd0, rd_addr},
               {2'd2, 14'd0, sp0});
         check(lat == 4, "R11 zero-wait latency", 32'(lat), 4);
         check(done_cnt - d0 == 1, "R11 single done", 32'(done_cnt - d0), 1);
      end
   endtask

   task automatic t_seg();
      logic [7:0] ops [0:2];
      int sidx [0:2];
      int lat; bit ill; int i0;
      ops[0] = 8'h07; ops[1] = 8'h17; ops[2] = 8'h1F;
      sidx[0] = 0; sidx[1] = 2; sidx[2] = 3;
      for (int k = 0; k < 3; k++) begin
         clear_regs();
         regs[4] = 16'h0080;
         smem[8'h40] = 16'hB100 + 16'(k);
         i0 = inh_cnt;
         run_pop(ops[k], 1'b0, 3'd0, 16'h0, 0, 1'b0, lat, ill);
         check(segs[sidx[k]] == 16'hB100 + 16'(k), "R2 segment destination", segs[sidx[k]], 16'hB100 + 16'(k));
         check(segs[1] == 16'h2001, "R2 CS untouched", segs[1], 16'h2001);
         check(inh_cnt - i0 == 1, "R5 inhibit one cycle", 32'(inh_cnt - i0), 1);
         check(regs[4] == 16'h0082, "R3 SP after segment pop", regs[4], 16'h0082);
      end
   endtask

   task automatic t_flags();
      int lat; bit ill; int i0;
      clear_regs();
      regs[4] = 16'h0010;
      smem[8'h08] = 16'hFFFF;
      flags_cur = 16'h0000;
      i0 = inh_cnt;
      run_pop(8'h9D, 1'b0, 3'd0, 16'h0, 0, 1'b0, lat, ill);
      check(flags_cur == 16'h0FD5, "R6 flags set from all-ones word", flags_cur, 16'h0FD5);
      check(inh_cnt == i0, "R5 no inhibit on flags pop", 32'(inh_cnt - i0), 0);
      regs[4] = 16'h0010;
      smem[8'h08] = 16'h0000;
      flags_cur = 16'hFFFF;
      run_pop(8'h9D, 1'b0, 3'd0, 16'h0, 0, 1'b0, lat, ill);
      check(flags_cur == 16'hF02A, "R6 unlisted flags kept", flags_cur, 16'hF02A);
      i0 = flw_cnt;
      regs[4] = 16'h0010;
      run_pop(8'h5A, 1'b0, 3'd0, 16'h0, 0, 1'b0, lat, ill);
      check(flw_cnt == i0 && flags_cur == 16'hF02A, "R6 gpr pop leaves flags", flags_cur, 16'hF02A);
   endtask

   task automatic t_mem();
      int lat; bit ill; int w0;
      clear_regs();
      regs[4] = 16'h0020;
      smem[8'h10] = 16'hC0DE;
      w0 = wr_cnt;
      run_pop(8'h8F, 1'b0, 3'd0, 16'h0064, 0, 1'b0, lat, ill);
      check(wr_cnt - w0 == 1, "R7 one memory write", 32'(wr_cnt - w0), 1);
      check(wr_addr == 16'h0064 && wr_seg == 2'd3, "R7 write at DS:ea", {wr_seg, 14'd0, wr_addr},
            {2'd3, 14'd0, 16'h0064});
      check(wr_data == 16'hC0DE, "R7 write data", wr_data, 16'hC0DE);
      check(sp_at_wr == 16'h0022, "R7 SP updated before write", sp_at_wr, 16'h0022);
      check(lat == 5, "R11 memory pop latency", 32'(lat), 5);
      regs[4] = 16'h0020;
      run_pop(8'h8F, 1'b0, 3'd0, 16'h0066, 2, 1'b0, lat, ill);
      check(lat == 9, "R9 waits stretch memory pop", 32'(lat), 9);
   endtask

   task automatic t_rm_reg();
      int lat; bit ill; int w0;
      clear_regs();
      regs[4] = 16'h0030;
      smem[8'h18] = 16'h5A5A;
      w0 = wr_cnt;
      run_pop(8'h8F, 1'b1, 3'd6, 16'h0070, 0, 1'b0, lat, ill);
      check(regs[6] == 16'h5A5A, "R8 rm register destination", regs[6], 16'h5A5A);
      check(wr_cnt == w0 && regs[4] == 16'h0032, "R8 no memory write, SP+2", regs[4], 16'h0032);
   endtask

   task automatic t_busy();
      int lat; bit ill; int r0;
      clear_regs();
      regs[4] = 16'h0050;
      smem[8'h28] = 16'h7777;
      r0 = rd_cnt;
      run_pop(8'h59, 1'b0, 3'd0, 16'h0, 3, 1'b1, lat, ill);
      check(lat == 7, "R9 read waits stretch done", 32'(lat), 7);
      check(regs[1] == 16'h7777, "R9 original pop completes", regs[1], 16'h7777);
      check(regs[3] == 16'h1003, "R9 start while busy ignored", regs[3], 16'h1003);
      check(rd_cnt - r0 == 1 && regs[4] == 16'h0052, "R9 single read", 32'(rd_cnt - r0), 1);
   endtask

   task automatic t_illegal();
      int lat; bit ill; int r0, w0, s0, f0;
      clear_regs();
      regs[4] = 16'h0060;
      r0 = rd_cnt; w0 = wr_cnt; s0 = sgw_cnt; f0 = flw_cnt;
      run_pop(8'h90, 1'b0, 3'd0, 16'h0, 0, 1'b0, lat, ill);
      check(ill == 1'b1 && lat == 1, "R10 illegal flagged next cycle", {31'd0, ill} + 32'(lat << 4), 32'h11);
      check(rd_cnt == r0 && wr_cnt == w0, "R10 no memory traffic", 32'(rd_cnt - r0), 0);
      check(regs[4] == 16'h0060 && sgw_cnt == s0 && flw_cnt == f0, "R10 no register effects", regs[4], 16'h0060);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      check(1'b0, "R11 global watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) smem[i] = 16'h0;
      clear_regs();
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_gpr();
      t_seg();
      t_flags();
      t_mem();
      t_rm_reg();
      t_busy();
      t_illegal();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule